// File: doc/BRIEF.md
# Bit-Plane Transposer

This block turns a frame of per-channel brightness words into bit planes for a binary-weighted modulation engine. Each plane word gathers one bit weight from every channel, so that a shift-register output stage can push a whole plane out at once and hold it for a time proportional to that weight. The least significant plane is plane 0. Only the upper bits of each brightness word are kept. Plane i takes input bit position i plus the difference between the input width and the number of planes.

A pass starts when an update request is seen. The request is taken into a pending flag. That flag clears as the pass begins, so a request that arrives during a pass queues exactly one more pass. The pass reads the frame buffer through a read port with a combinational response, one channel per clock. Channels form the inner loop and planes the outer loop. The block writes each finished plane word into the plane memory in a single cycle at its plane index. Planes that have not yet been rewritten keep their old contents, so the output engine may go on reading while a pass runs. A one-cycle done pulse follows the last write.

With the defaults there are 32 channels, which make 8 four-colour outputs, each using four consecutive channels. There are 14 planes and the input words are 16 bits wide, so plane i samples input bit i+2.

Top module: `bitplane_transposer`

## Requirements
- R1: After reset, busy, done and planeWe are all low.
- R2: In the word written for plane i, bit j equals bit (i + 2) of channel j's brightness word (in general, bit i + IN_W − PLANES).
- R3: An updReq pulse sampled at a rising edge makes busy high from the following rising edge onward.
- R4: During a pass, fbAddr steps through the channels 0 to 31 in ascending order, one per clock, for each plane in turn. busy stays high for exactly 448 consecutive cycles (32 × 14).
- R5: planeWe is high for one cycle per plane, only while busy is high. The writes go to plane addresses 0, 1, …, 13 in that order, and each plane is written exactly once per pass.
- R6: done is a single-cycle pulse. It is high in the cycle right after the write of plane 13, and busy is low in that cycle.
- R7: Any number of updReq pulses during a pass cause exactly one further pass after it ends, and no more.
- R8: Without an updReq pulse, no write occurs and busy stays low.
- R9: The two least significant bits of each brightness word do not affect any plane word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updReq | input | 1 | Frame-updated pulse; requests a pass |
| fbAddr | output | 5 | Channel index presented to the frame buffer |
| fbData | input | 16 | Brightness word of channel fbAddr, same cycle |
| planeWe | output | 1 | Plane memory write enable |
| planeAddr | output | 4 | Plane index being written |
| planeData | output | 32 | Plane word, bit j from channel j |
| busy | output | 1 | High while a pass is running |
| done | output | 1 | One-cycle pulse after the last plane write |

## Verification
The hardest case to reach is a set of update requests that land in the middle of a pass. These must merge into one extra pass that starts only after the current one ends. The bench waits about a hundred cycles into a pass and then pulses updReq twice. It then expects exactly two done pulses, 28 plane writes in order and a gap with busy low between the two runs, followed by a long quiet interval. The invariance of the low bits is checked by flipping only those bits and requiring the rewritten plane memory to match the previous pass.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // store the sampled bit of the current channel
    logic emit;     // last channel of a plane: the merged word is valid
  } dpStrobe_t;
endpackage

// File: rtl/bpt_ctrl.sv
module bpt_ctrl #(
  parameter int NUM_CH = 32,
  parameter int PLANES = 14,
  localparam int CW = $clog2(NUM_CH),
  localparam int PW = $clog2(PLANES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               updReq,
  output bpt_pkg::dpStrobe_t strb,
  output logic [CW-1:0]      chIdx,
  output logic [PW-1:0]      planeIdx,
  output logic               busy,
  output logic               done
);
  localparam logic [CW-1:0] CH_LAST = CW'(NUM_CH - 1);
  localparam logic [PW-1:0] PL_LAST = PW'(PLANES - 1);

  logic running;
  logic pending;
  logic start;
  logic lastCh;
  logic lastPl;

  assign start  = !running && pending;
  assign lastCh = (chIdx == CH_LAST);
  assign lastPl = (planeIdx == PL_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      pending  <= 1'b0;
      chIdx    <= '0;
      planeIdx <= '0;
      done     <= 1'b0;
    end else begin
      done    <= 1'b0;
      // a request in the start cycle is kept for the next pass
      pending <= updReq || (pending && !start);
      if (start) begin
        running  <= 1'b1;
        chIdx    <= '0;
        planeIdx <= '0;
      end else if (running) begin
        if (lastCh) begin
          chIdx <= '0;
          if (lastPl) begin
            running <= 1'b0;
            done    <= 1'b1;
          end else begin
            planeIdx <= planeIdx + 1'b1;
          end
        end else begin
          chIdx <= chIdx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.capture = running;
    strb.emit    = running && lastCh;
  end

  assign busy = running;
endmodule

// File: rtl/bpt_datapath.sv
module bpt_datapath #(
  parameter int NUM_CH = 32,
  parameter int PLANES = 14,
  parameter int IN_W   = 16,
  localparam int CW  = $clog2(NUM_CH),
  localparam int PW  = $clog2(PLANES),
  localparam int BW  = $clog2(IN_W),
  localparam int OFS = IN_W - PLANES
) (
  input  logic               clk,
  input  logic               rstN,
  input  bpt_pkg::dpStrobe_t strb,
  input  logic [CW-1:0]      chIdx,
  input  logic [PW-1:0]      planeIdx,
  input  logic [IN_W-1:0]    fbData,
  output logic [NUM_CH-1:0]  planeData
);
  logic [NUM_CH-1:0] acc;
  logic [BW-1:0]     bitPos;
  logic              selBit;

  assign bitPos = BW'(planeIdx) + BW'(OFS);
  assign selBit = fbData[bitPos];

  always_ff @(posedge clk) begin
    if (!rstN) acc <= '0;
    else if (strb.capture) acc[chIdx] <= selBit;
  end

  // merge the current channel's bit so the word is complete in its last cycle
  for (genvar j = 0; j < NUM_CH; j++) begin : g_merge
    assign planeData[j] = (chIdx == CW'(j)) ? selBit : acc[j];
  end
endmodule

// File: rtl/bitplane_transposer.sv
module bitplane_transposer #(
  parameter int NUM_CH = 32,
  parameter int PLANES = 14,
  parameter int IN_W   = 16,
  localparam int CW = $clog2(NUM_CH),
  localparam int PW = $clog2(PLANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              updReq,
  output logic [CW-1:0]     fbAddr,
  input  logic [IN_W-1:0]   fbData,
  output logic              planeWe,
  output logic [PW-1:0]     planeAddr,
  output logic [NUM_CH-1:0] planeData,
  output logic              busy,
  output logic              done
);
  bpt_pkg::dpStrobe_t strb;
  logic [CW-1:0] chIdx;
  logic [PW-1:0] planeIdx;

  bpt_ctrl #(.NUM_CH(NUM_CH), .PLANES(PLANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .updReq(updReq), .strb(strb),
    .chIdx(chIdx), .planeIdx(planeIdx), .busy(busy), .done(done)
  );

  bpt_datapath #(.NUM_CH(NUM_CH), .PLANES(PLANES), .IN_W(IN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .chIdx(chIdx),
    .planeIdx(planeIdx), .fbData(fbData), .planeData(planeData)
  );

  assign fbAddr    = chIdx;
  assign planeWe   = strb.emit;
  assign planeAddr = planeIdx;
endmodule

// File: rtl/bitplane_transposer_chk.sv
module bitplane_transposer_chk #(
  parameter int NUM_CH = 32,
  parameter int PLANES = 14,
  localparam int CW = $clog2(NUM_CH),
  localparam int PW = $clog2(PLANES)
) (
  input logic          clk,
  input logic          rstN,
  input logic [CW-1:0] fbAddr,
  input logic          planeWe,
  input logic [PW-1:0] planeAddr,
  input logic          busy,
  input logic          done
);
  p_we_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    planeWe |-> busy);

  p_addr_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    planeWe |-> (int'(planeAddr) < PLANES));

  p_plane_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (planeWe && int'(planeAddr) < PLANES - 1) |=> (busy && planeAddr == $past(planeAddr) + 1'b1));

  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(planeWe) && int'($past(planeAddr)) == PLANES - 1));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_chan_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && fbAddr != '0) |-> (fbAddr == $past(fbAddr) + 1'b1));

  p_start_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (fbAddr == '0 && planeAddr == '0));
endmodule

bind bitplane_transposer bitplane_transposer_chk #(.NUM_CH(NUM_CH), .PLANES(PLANES)) u_chk (.*);

// File: tb/bitplane_transposer_test.sv
module bitplane_transposer_test;
  localparam int NCH = 32;
  localparam int NPL = 14;
  localparam int IW  = 16;
  localparam int OFS = IW - NPL;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic updReq = 1'b0;
  logic [4:0]  fbAddr;
  logic [15:0] fbData;
  logic        planeWe;
  logic [3:0]  planeAddr;
  logic [31:0] planeData;
  logic        busy;
  logic        done;

  logic [15:0] fb [NCH];
  logic [31:0] mirror [NPL];
  logic [31:0] saved [NPL];

  typedef struct { int addr; logic [31:0] word; } item_t;
  item_t expQ [$];

  int checks = 0;
  int fails = 0;
  int doneCnt = 0;
  int writeCnt = 0;
  int runLen = 0;
  int expPlane = 0;
  bit prevLastWe = 1'b0;
  bit prevDone = 1'b0;

  always #5 clk = ~clk;

  assign fbData = fb[fbAddr];

  bitplane_transposer uut (
    .clk(clk), .rstN(rstN), .updReq(updReq), .fbAddr(fbAddr), .fbData(fbData),
    .planeWe(planeWe), .planeAddr(planeAddr), .planeData(planeData),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: push expected plane words computed from the bench frame buffer
  task automatic pushPass();
    for (int i = 0; i < NPL; i++) begin
      item_t it;
      it.addr = i;
      it.word = '0;
      for (int j = 0; j < NCH; j++) it.word[j] = fb[j][i + OFS];
      expQ.push_back(it);
    end
  endtask

  task automatic pulseReq();
    @(posedge clk); #2 updReq = 1'b1;
    @(posedge clk); #2 updReq = 1'b0;
  endtask

  task automatic waitDones(input int n);
    int target;
    target = doneCnt + n;
    while (doneCnt < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (planeWe) begin
        writeCnt++;
        mirror[planeAddr] = planeData;
        if (expQ.size() == 0) begin
          check(1'b0, "R8", "unexpected write", planeAddr, 0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(int'(planeAddr) == it.addr, "R5", "plane address", planeAddr, it.addr);
          check(planeData == it.word, "R2", "plane word", planeData, it.word);
        end
      end
      if (busy) begin
        if (int'(fbAddr) != runLen % NCH)
          check(1'b0, "R4", "channel order", fbAddr, runLen % NCH);
        runLen++;
      end else if (runLen > 0) begin
        check(runLen == NCH * NPL, "R4", "busy length", runLen, NCH * NPL);
        runLen = 0;
      end
      if (done) begin
        doneCnt++;
        check(prevLastWe && !busy && !prevDone, "R6", "done timing", {prevLastWe, busy, prevDone}, 3'b100);
      end
      prevDone = done;
      prevLastWe = planeWe && int'(planeAddr) == NPL - 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int w0;
    for (int j = 0; j < NCH; j++) fb[j] = 16'(j * 16'h0805 + 16'h1234);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!busy && !done && !planeWe, "R1", "reset outputs", {busy, done, planeWe}, 0);
    #2 rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !planeWe, "R1", "idle after reset", {busy, done, planeWe}, 0);

    // R3: busy one edge after the request edge
    pushPass();
    @(posedge clk); #2 updReq = 1'b1;
    @(posedge clk); #2 updReq = 1'b0;
    @(negedge clk);
    check(!busy, "R3", "busy before start edge", busy, 0);
    @(negedge clk);
    check(busy, "R3", "busy after start edge", busy, 1);
    waitDones(1);

    // R8: quiet interval
    w0 = writeCnt;
    repeat (200) @(negedge clk);
    check(writeCnt == w0 && !busy, "R8", "no activity without request", writeCnt - w0, 0);

    // R9: flip only the two lowest bits
    for (int i = 0; i < NPL; i++) saved[i] = mirror[i];
    for (int j = 0; j < NCH; j++) fb[j] = fb[j] ^ 16'h0003;
    pushPass();
    pulseReq();
    waitDones(1);
    for (int i = 0; i < NPL; i++)
      check(mirror[i] == saved[i], "R9", "plane unchanged by low bits", mirror[i], saved[i]);

    // all ones and alternating patterns
    for (int j = 0; j < NCH; j++) fb[j] = 16'hFFFF;
    pushPass(); pulseReq(); waitDones(1);
    for (int j = 0; j < NCH; j++) fb[j] = (j % 2 == 0) ? 16'hAAAA : 16'h5554;
    pushPass(); pulseReq(); waitDones(1);
    for (int j = 0; j < NCH; j++) fb[j] = 16'(16'h8000 >> (j % 16));
    pushPass(); pulseReq(); waitDones(1);

    // R7: two requests during a pass give exactly one more pass
    w0 = writeCnt;
    pushPass();
    pulseReq();
    repeat (100) @(negedge clk);
    pushPass();
    pulseReq();
    repeat (20) @(negedge clk);
    pulseReq();
    waitDones(2);
    repeat (600) @(negedge clk);
    check(writeCnt - w0 == 2 * NPL, "R7", "writes for merged requests", writeCnt - w0, 2 * NPL);
    check(!busy, "R7", "no third pass", busy, 0);
    check(expQ.size() == 0, "R5", "all planes written", expQ.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule